// File: doc/BRIEF.md
# Page-Offset-Indexed L1 Data Cache Lookup

This block performs the lookup of a set-associative L1 data cache whose set index and line offset both come from the untranslated page-offset bits of a load address. Because those bits are the same before and after translation, the set can be read in the cycle the request arrives, while the address translation is still running. The stored tags of that set are captured in a register. The tag compare waits until the translation strobe delivers the physical page number. That strobe may arrive any number of cycles after the request.

The tag of each line is the full physical page number. A match returns the addressed word of the line. A mismatch is reported as a miss, together with the physical line address, so the next level of the hierarchy can fetch the line. A translation fault abandons the pending lookup and leaves the cache untouched. Lines are written by a fill port, one whole line at a time. The fill port places a line in the lowest-numbered free way of its set, or else in the way picked by a per-set pseudo-LRU tree. Stores are assumed to be written through elsewhere, so no line is ever dirty.

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1 and `resp_valid` and `miss_valid` are 0, so the first lookup of any address misses.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 while a lookup waits for its translation and in any cycle where `fill_valid` is 1.
- R3: `req_word` is the page offset in word units. Its upper IDX_W bits select the set and its lower WSEL_W bits select the word. Word j of a line is bits [j*WORD_W +: WORD_W] of the filled line.
- R4: While a lookup waits, the edge that samples `xlat_valid`=1 with `xlat_fault`=0 completes it, whatever the wait was. The lookup hits exactly when a valid way of the set held at request time has a tag equal to `xlat_ppn`.
- R5: A completed lookup raises `resp_valid` for exactly one cycle, starting after the completing edge. On a hit `resp_hit` is 1 and `resp_data` is the selected word.
- R6: On a miss `resp_hit` is 0 and `resp_data` is 0. `miss_valid` pulses with `resp_valid`, and `miss_ppn` and `miss_idx` carry the physical page number and set of the missing line.
- R7: `xlat_fault`=1 while a lookup waits ends it, taking priority over `xlat_valid`. No response or miss is produced, and no valid bit, tag or replacement state changes.
- R8: A fill writes the whole line, its tag `fill_ppn` and its valid bit in one edge, into set `fill_idx`. Any later lookup of that line hits.
- R9: A fill uses the lowest-numbered invalid way of its set. If all ways are valid, it uses the way reached by walking the set's tree from the root, going to child 2n+b[n] at node n (nodes 1..WAYS-1). The way is the final node number minus WAYS.
- R10: A hit and a fill each update the tree of their set. On the path to their way, each node is set to point away from it: b[n] becomes the inverse of the direction taken. If a hit and a fill touch the same set on the same edge, only the fill's update applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Lookup can be taken this cycle |
| req_word | input | IDX_W+WSEL_W | Page offset in word units (set, word) |
| xlat_valid | input | 1 | Translation result valid |
| xlat_fault | input | 1 | Translation failed; abandon the lookup |
| xlat_ppn | input | PPN_W | Translated physical page number |
| fill_valid | input | 1 | Write a line |
| fill_ppn | input | PPN_W | Tag of the filled line |
| fill_idx | input | IDX_W | Set of the filled line |
| fill_line | input | LINE_W | Whole line contents |
| resp_valid | output | 1 | Lookup completed |
| resp_hit | output | 1 | Completed lookup hit |
| resp_data | output | WORD_W | Selected word on a hit, else 0 |
| miss_valid | output | 1 | Miss request to the next level |
| miss_ppn | output | PPN_W | Physical page number of the missing line |
| miss_idx | output | IDX_W | Set of the missing line |

## Verification
The bench builds the block with 4 sets of 4 ways, 16-byte lines of 32-bit words and an 8-bit page number. With this small geometry, a few fills fill a whole set. Evictions, pseudo-LRU victim choices and hits after replacement then come up often within a few hundred random operations. A small pool of page numbers makes lookups hit and miss about equally often. Random translation delays of zero to three cycles and random faults exercise the held-set compare and the silent abandon. A directed sequence checks that a fault leaves the replacement order unchanged.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    // Lookup sequencing: idle, or set captured and waiting for the page number
    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_WAIT = 1'b1
    } lk_state_e;

    // Flags registered with every completed lookup
    typedef struct packed {
        logic valid;
        logic hit;
        logic miss;
    } lk_resp_t;

endpackage

// File: rtl/vipt_plru.sv
module vipt_plru #(
    parameter int SETS = 64,
    parameter int WAYS = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(SETS)-1:0]   qry_idx,
    output logic [$clog2(WAYS)-1:0]   victim,
    input  logic                      hit_en,
    input  logic [$clog2(SETS)-1:0]   hit_idx,
    input  logic [$clog2(WAYS)-1:0]   hit_way,
    input  logic                      fill_en,
    input  logic [$clog2(SETS)-1:0]   fill_idx,
    input  logic [$clog2(WAYS)-1:0]   fill_way
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    // Heap-ordered tree bits, node 1 is the root
    logic [WAYS-1:1] tree_q [SETS];

    function automatic logic [WAYS-1:1] tree_touch(input logic [WAYS-1:1] t,
                                                   input logic [WAY_W-1:0] w);
        logic [WAYS-1:1] r;
        logic [WAY_W:0]  n;
        r = t;
        n = (WAY_W+1)'(1);
        for (int l = WAY_W-1; l >= 0; l--) begin
            r[n[WAY_W-1:0]] = ~w[l];
            n = {n[WAY_W-1:0], w[l]};
        end
        return r;
    endfunction

    function automatic logic [WAY_W-1:0] tree_pick(input logic [WAYS-1:1] t);
        logic [WAY_W:0] n;
        n = (WAY_W+1)'(1);
        for (int l = 0; l < WAY_W; l++) begin
            n = {n[WAY_W-1:0], t[n[WAY_W-1:0]]};
        end
        return n[WAY_W-1:0];
    endfunction

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                tree_q[s] <= '0;
            end else if (fill_en && fill_idx == IDX_W'(s)) begin
                tree_q[s] <= tree_touch(tree_q[s], fill_way);
            end else if (hit_en && hit_idx == IDX_W'(s)) begin
                tree_q[s] <= tree_touch(tree_q[s], hit_way);
            end
        end
    end

    assign victim = tree_pick(tree_q[qry_idx]);

    AST_HIT_NOT_VICTIM: assert property (@(posedge clk) disable iff (rst)
        (hit_en && !(fill_en && fill_idx == hit_idx))
        |=> (tree_pick(tree_q[$past(hit_idx)]) != $past(hit_way))); // R10

endmodule

// File: rtl/vipt_tag_array.sv
module vipt_tag_array #(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int PPN_W = 40
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [$clog2(SETS)-1:0]           rd_idx,
    output logic [WAYS-1:0][PPN_W-1:0]        rd_tags,
    output logic [WAYS-1:0]                   rd_valid,
    input  logic [$clog2(SETS)-1:0]           wr_idx,
    output logic [WAYS-1:0]                   wr_row_valid,
    input  logic                              wr_en,
    input  logic [$clog2(WAYS)-1:0]           wr_way,
    input  logic [PPN_W-1:0]                  wr_tag
);
    localparam int IDX_W = $clog2(SETS);

    logic [PPN_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][wr_way] <= wr_tag;
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_vld
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[s] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(s)) begin
                vld_q[s][wr_way] <= 1'b1;
            end
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tags[w] = tag_q[rd_idx][w];
        end
    end

    assign rd_valid     = vld_q[rd_idx];
    assign wr_row_valid = vld_q[wr_idx];

    AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_idx)][$past(wr_way)]); // R8

endmodule

// File: rtl/vipt_tag_match.sv
module vipt_tag_match #(
    parameter int WAYS  = 8,
    parameter int PPN_W = 40
) (
    input  logic [WAYS-1:0][PPN_W-1:0] tags,
    input  logic [WAYS-1:0]            valid,
    input  logic [PPN_W-1:0]           ppn,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [$clog2(WAYS)-1:0]    hit_way
);
    localparam int WAY_W = $clog2(WAYS);

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = valid[w] && (tags[w] == ppn);
        end
        for (int w = WAYS-1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/vipt_data_array.sv
module vipt_data_array #(
    parameter int SETS       = 64,
    parameter int WAYS       = 8,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 8
) (
    input  logic                                    clk,
    input  logic                                    wr_en,
    input  logic [$clog2(SETS)-1:0]                 wr_idx,
    input  logic [$clog2(WAYS)-1:0]                 wr_way,
    input  logic [LINE_BYTES*8-1:0]                 wr_line,
    input  logic [$clog2(SETS)-1:0]                 rd_idx,
    input  logic [$clog2(WAYS)-1:0]                 rd_way,
    input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0] rd_wsel,
    output logic [WORD_BYTES*8-1:0]                 rd_word
);
    localparam int LINE_W  = LINE_BYTES*8;
    localparam int WORD_W  = WORD_BYTES*8;
    localparam int WORDS   = LINE_BYTES/WORD_BYTES;
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int ENTRIES = SETS*WAYS;

    logic [LINE_W-1:0] line_q [ENTRIES];
    logic [LINE_W-1:0] rd_line;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[{wr_idx, wr_way}] <= wr_line;
        end
    end

    assign rd_line = line_q[{rd_idx, rd_way}];

    always_comb begin
        rd_word = '0;
        for (int j = 0; j < WORDS; j++) begin
            if (rd_wsel == WSEL_W'(j)) begin
                rd_word = rd_line[j*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int SETS       = 64,
    parameter int WAYS       = 8,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 8,
    parameter int PPN_W      = 40,
    localparam int IDX_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int WSEL_W    = $clog2(LINE_BYTES/WORD_BYTES),
    localparam int LINE_W    = LINE_BYTES*8,
    localparam int WORD_W    = WORD_BYTES*8,
    localparam int REQ_W     = IDX_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [REQ_W-1:0]  req_word,
    input  logic              xlat_valid,
    input  logic              xlat_fault,
    input  logic [PPN_W-1:0]  xlat_ppn,
    input  logic              fill_valid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [LINE_W-1:0] fill_line,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WORD_W-1:0] resp_data,
    output logic              miss_valid,
    output logic [PPN_W-1:0]  miss_ppn,
    output logic [IDX_W-1:0]  miss_idx
);
    lk_state_e                 state_q;
    lk_resp_t                  resp_q;
    logic [IDX_W-1:0]          req_idx, held_idx_q;
    logic [WSEL_W-1:0]         req_wsel, held_wsel_q;
    logic [WAYS-1:0][PPN_W-1:0] set_tags, snap_tags_q;
    logic [WAYS-1:0]           set_valid, snap_valid_q;
    logic [WAYS-1:0]           fill_row_valid;
    logic [WAYS-1:0]           hit_vec;
    logic                      hit;
    logic [WAY_W-1:0]          hit_way;
    logic [WAY_W-1:0]          plru_way, free_way, victim_way;
    logic                      any_free;
    logic [WORD_W-1:0]         rd_word;
    logic                      accept, complete, touch_hit;

    assign req_idx  = req_word[REQ_W-1:WSEL_W];
    assign req_wsel = req_word[WSEL_W-1:0];

    assign req_ready = (state_q == LK_IDLE) && !fill_valid;
    assign accept    = req_valid && req_ready;
    assign complete  = (state_q == LK_WAIT) && xlat_valid && !xlat_fault;
    assign touch_hit = complete && hit;

    vipt_tag_array #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .PPN_W (PPN_W)
    ) u_tags (
        .clk          (clk),
        .rst          (rst),
        .rd_idx       (req_idx),
        .rd_tags      (set_tags),
        .rd_valid     (set_valid),
        .wr_idx       (fill_idx),
        .wr_row_valid (fill_row_valid),
        .wr_en        (fill_valid),
        .wr_way       (victim_way),
        .wr_tag       (fill_ppn)
    );

    vipt_tag_match #(
        .WAYS  (WAYS),
        .PPN_W (PPN_W)
    ) u_match (
        .tags    (snap_tags_q),
        .valid   (snap_valid_q),
        .ppn     (xlat_ppn),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_way (hit_way)
    );

    vipt_data_array #(
        .SETS       (SETS),
        .WAYS       (WAYS),
        .LINE_BYTES (LINE_BYTES),
        .WORD_BYTES (WORD_BYTES)
    ) u_data (
        .clk     (clk),
        .wr_en   (fill_valid),
        .wr_idx  (fill_idx),
        .wr_way  (victim_way),
        .wr_line (fill_line),
        .rd_idx  (held_idx_q),
        .rd_way  (hit_way),
        .rd_wsel (held_wsel_q),
        .rd_word (rd_word)
    );

    vipt_plru #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_plru (
        .clk      (clk),
        .rst      (rst),
        .qry_idx  (fill_idx),
        .victim   (plru_way),
        .hit_en   (touch_hit),
        .hit_idx  (held_idx_q),
        .hit_way  (hit_way),
        .fill_en  (fill_valid),
        .fill_idx (fill_idx),
        .fill_way (victim_way)
    );

    // Lowest-numbered free way of the fill set
    always_comb begin
        free_way = '0;
        any_free = 1'b0;
        for (int w = WAYS-1; w >= 0; w--) begin
            if (!fill_row_valid[w]) begin
                free_way = WAY_W'(w);
                any_free = 1'b1;
            end
        end
    end

    assign victim_way = any_free ? free_way : plru_way;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= LK_IDLE;
            resp_q       <= '0;
            resp_data    <= '0;
            miss_ppn     <= '0;
            miss_idx     <= '0;
            held_idx_q   <= '0;
            held_wsel_q  <= '0;
            snap_valid_q <= '0;
            snap_tags_q  <= '0;
        end else begin
            resp_q.valid <= 1'b0;
            resp_q.miss  <= 1'b0;
            unique case (state_q)
                LK_IDLE: begin
                    if (accept) begin
                        state_q      <= LK_WAIT;
                        held_idx_q   <= req_idx;
                        held_wsel_q  <= req_wsel;
                        snap_tags_q  <= set_tags;
                        snap_valid_q <= set_valid;
                    end
                end
                LK_WAIT: begin
                    if (xlat_fault) begin
                        state_q <= LK_IDLE;
                    end else if (xlat_valid) begin
                        state_q      <= LK_IDLE;
                        resp_q.valid <= 1'b1;
                        resp_q.hit   <= hit;
                        resp_q.miss  <= !hit;
                        resp_data    <= hit ? rd_word : '0;
                        miss_ppn     <= xlat_ppn;
                        miss_idx     <= held_idx_q;
                    end
                end
                default: state_q <= LK_IDLE;
            endcase
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_hit   = resp_q.hit;
    assign miss_valid = resp_q.miss;

    AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_STROBE_COMPLETES: assert property (@(posedge clk) disable iff (rst)
        complete |=> resp_valid); // R4

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (state_q == LK_WAIT) |-> $onehot0(hit_vec)); // R4

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid); // R5

    AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> (miss_valid && resp_data == '0)); // R6

    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((state_q == LK_WAIT) && xlat_fault) |=> (!resp_valid && !miss_valid)); // R7

    AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !(&fill_row_valid)) |-> !fill_row_valid[victim_way]); // R9

endmodule

// File: tb/vipt_cache_bench.sv
module vipt_cache_bench;
    localparam int SETS = 4, WAYS = 4, LB = 16, WB = 4, PPN_W = 8;
    localparam int IDX_W = 2, WAY_W = 2, WSEL_W = 2;
    localparam int LINE_W = LB*8, WORD_W = WB*8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [IDX_W+WSEL_W-1:0] req_word = '0;
    logic xlat_valid = 1'b0, xlat_fault = 1'b0;
    logic [PPN_W-1:0] xlat_ppn = '0;
    logic fill_valid = 1'b0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic [IDX_W-1:0] fill_idx = '0;
    logic [LINE_W-1:0] fill_line = '0;
    logic resp_valid, resp_hit, miss_valid;
    logic [WORD_W-1:0] resp_data;
    logic [PPN_W-1:0] miss_ppn;
    logic [IDX_W-1:0] miss_idx;

    int checks = 0;
    int errors = 0;

    // Reference state, kept from the requirements
    bit              m_valid [SETS][WAYS];
    logic [PPN_W-1:0] m_tag  [SETS][WAYS];
    logic [LINE_W-1:0] m_data [SETS][WAYS];
    bit [WAYS-1:0]   m_tree [SETS];

    always #4 clk = ~clk;

    vipt_cache #(
        .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LB), .WORD_BYTES(WB), .PPN_W(PPN_W)
    ) u_vipt_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_word(req_word),
        .xlat_valid(xlat_valid), .xlat_fault(xlat_fault), .xlat_ppn(xlat_ppn),
        .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_idx(fill_idx), .fill_line(fill_line),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .miss_valid(miss_valid), .miss_ppn(miss_ppn), .miss_idx(miss_idx)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_victim(input int s);
        int n;
        for (int w = 0; w < WAYS; w++) if (!m_valid[s][w]) return w;
        n = 1;
        for (int l = 0; l < WAY_W; l++) n = 2*n + int'(m_tree[s][n]);
        return n - WAYS;
    endfunction

    task automatic m_touch(input int s, input int w);
        int n = 1;
        for (int l = WAY_W-1; l >= 0; l--) begin
            int b = (w >> l) & 1;
            m_tree[s][n] = (b == 0);
            n = 2*n + b;
        end
    endtask

    function automatic int m_find(input int s, input logic [PPN_W-1:0] p);
        for (int w = 0; w < WAYS; w++) if (m_valid[s][w] && m_tag[s][w] == p) return w;
        return -1;
    endfunction

    function automatic logic [LINE_W-1:0] rand_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Starts and ends at a falling edge
    task automatic do_fill(input logic [PPN_W-1:0] p, input int s, input logic [LINE_W-1:0] ln);
        int v;
        fill_valid = 1'b1; fill_ppn = p; fill_idx = IDX_W'(s); fill_line = ln;
        #1;
        chk(req_ready == 1'b0, "R2 ready low during fill", 128'(req_ready), 0);
        v = m_victim(s);
        @(posedge clk);
        m_valid[s][v] = 1'b1; m_tag[s][v] = p; m_data[s][v] = ln;
        m_touch(s, v);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [PPN_W-1:0] p, input int s, input int ws,
                             input int dly, input bit fault, input bit both);
        int w;
        logic [WORD_W-1:0] exp_d;
        req_valid = 1'b1; req_word = {IDX_W'(s), WSEL_W'(ws)};
        #1;
        chk(req_ready == 1'b1, "R2 ready when idle", 128'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 ready low while waiting", 128'(req_ready), 0);
        for (int i = 0; i < dly; i++) begin
            xlat_ppn = PPN_W'($urandom);
            @(negedge clk);
            chk(resp_valid == 1'b0, "R4 no response before strobe", 128'(resp_valid), 0);
        end
        xlat_ppn = p; xlat_fault = fault; xlat_valid = !fault || both;
        @(posedge clk);
        @(negedge clk);
        xlat_valid = 1'b0; xlat_fault = 1'b0;
        if (fault) begin
            chk(resp_valid == 1'b0 && miss_valid == 1'b0, "R7 fault gives no response",
                128'({resp_valid, miss_valid}), 0);
        end else begin
            w = m_find(s, p);
            chk(resp_valid == 1'b1, "R5 response pulse", 128'(resp_valid), 1);
            chk(resp_hit == (w >= 0), "R4 hit decision", 128'(resp_hit), 128'(w >= 0));
            if (w >= 0) begin
                exp_d = m_data[s][w][ws*WORD_W +: WORD_W];
                chk(resp_data == exp_d, "R3 hit word", 128'(resp_data), 128'(exp_d));
                m_touch(s, w);
            end else begin
                chk(miss_valid == 1'b1 && resp_data == '0, "R6 miss pulse and zero data",
                    128'({miss_valid, resp_data}), 128'({1'b1, 32'h0}));
                chk(miss_ppn == p && miss_idx == IDX_W'(s), "R6 miss line address",
                    128'({miss_ppn, miss_idx}), 128'({p, IDX_W'(s)}));
            end
            @(negedge clk);
            chk(resp_valid == 1'b0, "R5 single-cycle response", 128'(resp_valid), 0);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [LINE_W-1:0] ln;
        void'($urandom(32'd20517));
        for (int s = 0; s < SETS; s++) begin
            m_tree[s] = '0;
            for (int w = 0; w < WAYS; w++) m_valid[s][w] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(req_ready == 1'b1 && resp_valid == 1'b0 && miss_valid == 1'b0, "R1 reset outputs",
            128'({req_ready, resp_valid, miss_valid}), 128'(3'b100));
        @(negedge clk);

        // R1 empty cache misses; R6 miss address
        do_lookup(8'h05, 1, 2, 0, 0, 0);
        // R8 fill then R3 every word of the line
        ln = rand_line();
        do_fill(8'h05, 1, ln);
        for (int ws = 0; ws < 4; ws++) do_lookup(8'h05, 1, ws, 0, 0, 0);
        // R4 late translation, same page offset, other page
        do_lookup(8'h05, 1, 1, 3, 0, 0);
        do_lookup(8'h06, 1, 1, 2, 0, 0);
        // R9 free ways first, then the tree
        for (int k = 0; k < 4; k++) do_fill(PPN_W'(8'h10 + k), 2, rand_line());
        do_lookup(8'h10, 2, 0, 0, 0, 0);
        // R7 fault, alone and with the strobe, touches nothing
        do_lookup(8'h11, 2, 0, 1, 1, 0);
        do_lookup(8'h12, 2, 0, 0, 1, 1);
        // R10 replacement order after the hit decides the victim
        do_fill(8'h14, 2, rand_line());
        for (int k = 0; k < 5; k++) do_lookup(PPN_W'(8'h10 + k), 2, 3, 0, 0, 0);
        do_fill(8'h15, 2, rand_line());
        for (int k = 0; k < 6; k++) do_lookup(PPN_W'(8'h10 + k), 2, 0, 1, 0, 0);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int s = int'($urandom_range(0, SETS-1));
            logic [PPN_W-1:0] p = PPN_W'($urandom_range(0, 5));
            if ($urandom_range(0, 9) < 4 && m_find(s, p) < 0) begin
                do_fill(p, s, rand_line());
            end else begin
                bit f = ($urandom_range(0, 9) == 0);
                do_lookup(p, s, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                          f, f && $urandom_range(0, 1) == 1);
            end
        end
        finish_run();
    end

endmodule